// File: doc/BRIEF.md
# Vector Register Readiness Scoreboard

This block keeps a record of which vector registers still wait on a result. The state has two halves, one bit per register in each. The issue logic marks a register as busy in one or both halves by setting bits. Every completion event then releases that register in both halves at once. Three kinds of event release bits: a register write on any of the write ports, a write hint that carries no data, and a deferred clear of the accumulator bank.

The accumulator bank is a run of registers that starts at a fixed base. Its length is the vector width divided by 32. An accepted accumulator-clear strobe releases that run on the following clock edge, not on the edge where the strobe arrives. In any cycle, all releases are applied first and the set request is merged last. The whole scoreboard is presented as a single registered vector.

Top module: `sb_top`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every bit of `sbState` is 0.
- R2: A write port with its valid high and address r clears bit r (low half) and bit r+NUM_REGS (high half) of `sbState`, visible after the next clock edge.
- R3: A hint port with its valid high and address r clears the same two bits as a write to r, with the same one-edge latency.
- R4: With `setValid` high, `setBits` is ORed into the state. `setBits` bit i lands on `sbState` bit i, so bits 0 to NUM_REGS-1 form the low half and the rest form the high half.
- R5: A set bit and a write or hint release of the same bit in the same cycle leave the bit at 1.
- R6: A `wclrFire` pulse in cycle N clears the accumulator bits of both halves on the clock edge that ends cycle N+1. Those bits are therefore still set directly after the edge that ends cycle N.
- R7: The accumulator bits are registers ACC_BASE to ACC_BASE+VEC_BITS/32-1 (48 to 55 with the defaults). The deferred clear leaves every register outside that range unchanged.
- R8: A set that arrives in the cycle the deferred accumulator clear is applied overrides that clear for the bits it sets.
- R9: Address inputs of ports whose valid is low have no effect, and no bit rises to 1 without a set.
- R10: Several ports releasing in the same cycle, including two ports with the same address, all take effect together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrValid | input | NUM_WR | Valid for each write port |
| wrAddr | input | NUM_WR*log2(NUM_REGS) | Write addresses, port p at bits p*6 upward |
| hintValid | input | NUM_HINT | Valid for each hint port |
| hintAddr | input | NUM_HINT*log2(NUM_REGS) | Hint addresses, port p at bits p*6 upward |
| setValid | input | 1 | Merge `setBits` this cycle |
| setBits | input | 2*NUM_REGS | Bits to mark busy |
| wclrFire | input | 1 | Accepted accumulator-clear command |
| sbState | output | 2*NUM_REGS | Registered scoreboard, low half in the lower bits |

## Verification
The bench builds the block with 64 registers, six write ports, four hint ports, an accumulator base of 48 and 256-bit vectors. With these values the deferred clear covers registers 48 to 55. Registers 47 and 56 sit directly outside the range, so a wrong range length or base shows up as a flipped neighbour. Six write ports plus four hints make it possible to release ten registers in one cycle, to give two ports the same address, and to land a set on the exact edge of a deferred clear.

// File: rtl/sb_pkg.sv
package sb_pkg;
  // Strobes passed from control to datapath each cycle.
  typedef struct packed {
    logic portClr;  // at least one write or hint release is present
    logic accClr;   // deferred accumulator-bank release is due now
  } sbStrobe_t;
endpackage

// File: rtl/sb_ctrl.sv
module sb_ctrl #(
  parameter int NUM_REGS = 64,
  parameter int NUM_WR   = 6,
  parameter int NUM_HINT = 4,
  localparam int AW      = $clog2(NUM_REGS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_WR-1:0]      wrValid,
  input  logic [NUM_WR*AW-1:0]   wrAddr,
  input  logic [NUM_HINT-1:0]    hintValid,
  input  logic [NUM_HINT*AW-1:0] hintAddr,
  input  logic                   wclrFire,
  output logic [NUM_REGS-1:0]    clrMask,
  output sb_pkg::sbStrobe_t      strobes
);
  localparam int NUM_SRC = NUM_WR + NUM_HINT;
  localparam logic [NUM_REGS-1:0] ONE_HOT0 = {{(NUM_REGS-1){1'b0}}, 1'b1};

  logic [NUM_REGS-1:0] srcHit [NUM_SRC];
  logic wclrDly;

  // One decoder per release source; write ports first, then hints.
  for (genvar p = 0; p < NUM_WR; p++) begin : g_wr
    assign srcHit[p] = wrValid[p] ? (ONE_HOT0 << wrAddr[p*AW +: AW]) : '0;
  end
  for (genvar h = 0; h < NUM_HINT; h++) begin : g_hint
    assign srcHit[NUM_WR+h] = hintValid[h] ? (ONE_HOT0 << hintAddr[h*AW +: AW]) : '0;
  end

  always_comb begin
    clrMask = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      clrMask = clrMask | srcHit[s];
    end
  end

  // The bank clear takes effect one edge after the command is accepted.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wclrDly <= 1'b0;
    else       wclrDly <= wclrFire;
  end

  always_comb begin
    strobes.portClr = |clrMask;
    strobes.accClr  = wclrDly;
  end
endmodule

// File: rtl/sb_datapath.sv
module sb_datapath #(
  parameter int NUM_REGS   = 64,
  parameter int NUM_HALVES = 2,
  parameter int ACC_BASE   = 48,
  parameter int ACC_CNT    = 8,
  localparam int SW        = NUM_HALVES * NUM_REGS
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                setValid,
  input  logic [SW-1:0]       setBits,
  input  logic [NUM_REGS-1:0] clrMask,
  input  sb_pkg::sbStrobe_t   strobes,
  output logic [SW-1:0]       sbState
);
  function automatic logic [NUM_REGS-1:0] mkAccMask();
    logic [NUM_REGS-1:0] m;
    for (int i = 0; i < NUM_REGS; i++) begin
      m[i] = (i >= ACC_BASE) && (i < ACC_BASE + ACC_CNT);
    end
    return m;
  endfunction

  localparam logic [NUM_REGS-1:0] ACC_MASK = mkAccMask();

  logic [NUM_REGS-1:0] relMask;

  always_comb begin
    relMask = '0;
    if (strobes.portClr) relMask = relMask | clrMask;
    if (strobes.accClr)  relMask = relMask | ACC_MASK;
  end

  // Each half sees the same releases; its own slice of setBits is merged last.
  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    logic [NUM_REGS-1:0] q;
    logic [NUM_REGS-1:0] d;
    always_comb begin
      d = q & ~relMask;
      if (setValid) d = d | setBits[h*NUM_REGS +: NUM_REGS];
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= '0;
      else       q <= d;
    end
    assign sbState[h*NUM_REGS +: NUM_REGS] = q;
  end
endmodule

// File: rtl/sb_top.sv
module sb_top #(
  parameter int NUM_REGS = 64,
  parameter int NUM_WR   = 6,
  parameter int NUM_HINT = 4,
  parameter int VEC_BITS = 256,
  parameter int ACC_BASE = 48,
  localparam int AW      = $clog2(NUM_REGS),
  localparam int SW      = 2 * NUM_REGS
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_WR-1:0]      wrValid,
  input  logic [NUM_WR*AW-1:0]   wrAddr,
  input  logic [NUM_HINT-1:0]    hintValid,
  input  logic [NUM_HINT*AW-1:0] hintAddr,
  input  logic                   setValid,
  input  logic [SW-1:0]          setBits,
  input  logic                   wclrFire,
  output logic [SW-1:0]          sbState
);
  localparam int ACC_CNT = VEC_BITS / 32;

  logic [NUM_REGS-1:0] clrMask;
  sb_pkg::sbStrobe_t   strobes;

  sb_ctrl #(
    .NUM_REGS(NUM_REGS), .NUM_WR(NUM_WR), .NUM_HINT(NUM_HINT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .wrValid(wrValid), .wrAddr(wrAddr),
    .hintValid(hintValid), .hintAddr(hintAddr),
    .wclrFire(wclrFire),
    .clrMask(clrMask), .strobes(strobes)
  );

  sb_datapath #(
    .NUM_REGS(NUM_REGS), .NUM_HALVES(2), .ACC_BASE(ACC_BASE), .ACC_CNT(ACC_CNT)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .setValid(setValid), .setBits(setBits),
    .clrMask(clrMask), .strobes(strobes),
    .sbState(sbState)
  );
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int NUM_REGS = 64,
  parameter int NUM_WR   = 6,
  parameter int NUM_HINT = 4,
  parameter int VEC_BITS = 256,
  parameter int ACC_BASE = 48,
  localparam int AW      = $clog2(NUM_REGS),
  localparam int SW      = 2 * NUM_REGS
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [NUM_WR-1:0]      wrValid,
  input logic [NUM_WR*AW-1:0]   wrAddr,
  input logic [NUM_HINT-1:0]    hintValid,
  input logic [NUM_HINT*AW-1:0] hintAddr,
  input logic                   setValid,
  input logic [SW-1:0]          setBits,
  input logic                   wclrFire,
  input logic [SW-1:0]          sbState
);
  function automatic logic [NUM_REGS-1:0] accRange();
    logic [NUM_REGS-1:0] m;
    for (int i = 0; i < NUM_REGS; i++) begin
      m[i] = (i >= ACC_BASE) && (i < ACC_BASE + VEC_BITS / 32);
    end
    return m;
  endfunction
  localparam logic [NUM_REGS-1:0] ACC_RANGE = accRange();

  logic [NUM_REGS-1:0] loHalf, hiHalf;
  assign loHalf = sbState[NUM_REGS-1:0];
  assign hiHalf = sbState[SW-1:NUM_REGS];

  // R1
  a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (sbState == '0));

  // R4
  a_r4_set_sticks: assert property (@(posedge clk) disable iff (!rstN)
    setValid |=> ((sbState & $past(setBits)) == $past(setBits)));

  // R9
  a_r9_no_rise_without_set: assert property (@(posedge clk) disable iff (!rstN)
    !setValid |=> ((sbState & ~$past(sbState)) == '0));

  // R6
  a_r6_acc_released: assert property (@(posedge clk) disable iff (!rstN)
    ($past(wclrFire) && !setValid) |=> (((loHalf | hiHalf) & ACC_RANGE) == '0));

  for (genvar p = 0; p < NUM_WR; p++) begin : g_wrchk
    // R2
    a_r2_write_clears: assert property (@(posedge clk) disable iff (!rstN)
      (wrValid[p] && !setValid) |=>
        (!loHalf[$past(wrAddr[p*AW +: AW])] && !hiHalf[$past(wrAddr[p*AW +: AW])]));
  end

  for (genvar h = 0; h < NUM_HINT; h++) begin : g_hintchk
    // R3
    a_r3_hint_clears: assert property (@(posedge clk) disable iff (!rstN)
      (hintValid[h] && !setValid) |=>
        (!loHalf[$past(hintAddr[h*AW +: AW])] && !hiHalf[$past(hintAddr[h*AW +: AW])]));
  end
endmodule

bind sb_top sb_checker #(
  .NUM_REGS(NUM_REGS), .NUM_WR(NUM_WR), .NUM_HINT(NUM_HINT),
  .VEC_BITS(VEC_BITS), .ACC_BASE(ACC_BASE)
) u_chk (
  .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr),
  .hintValid(hintValid), .hintAddr(hintAddr), .setValid(setValid),
  .setBits(setBits), .wclrFire(wclrFire), .sbState(sbState)
);

// File: tb/sb_top_tb.sv
module sb_top_tb;
  localparam int NR = 64;
  localparam int NW = 6;
  localparam int NH = 4;
  localparam int VB = 256;
  localparam int AB = 48;
  localparam int AW = 6;
  localparam int SW = 2 * NR;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NW-1:0]    wrValid;
  logic [NW*AW-1:0] wrAddr;
  logic [NH-1:0]    hintValid;
  logic [NH*AW-1:0] hintAddr;
  logic             setValid;
  logic [SW-1:0]    setBits;
  logic             wclrFire;
  logic [SW-1:0]    sbState;

  sb_top #(.NUM_REGS(NR), .NUM_WR(NW), .NUM_HINT(NH), .VEC_BITS(VB), .ACC_BASE(AB)) u_dut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr),
    .hintValid(hintValid), .hintAddr(hintAddr), .setValid(setValid),
    .setBits(setBits), .wclrFire(wclrFire), .sbState(sbState)
  );

  // 200 MHz: 5-unit period in ns.
  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Behavioural reference: per-register busy flags in two halves.
  bit refLo [NR];
  bit refHi [NR];
  bit refPend = 1'b0;

  function automatic bit inAcc(int r);
    return (r >= AB) && (r < AB + VB / 32);
  endfunction

  function automatic logic [SW-1:0] refVec();
    logic [SW-1:0] v;
    for (int r = 0; r < NR; r++) begin
      v[r]      = refLo[r];
      v[NR + r] = refHi[r];
    end
    return v;
  endfunction

  task automatic check(string req, logic [SW-1:0] act, logic [SW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    wrValid = '0; hintValid = '0; setValid = 1'b0; wclrFire = 1'b0;
    setBits = '0;
  endtask

  // Advance one clock, update the reference, then compare after the edge.
  task automatic tick(string req);
    bit rel [NR];
    @(posedge clk);
    if (!rstN) begin
      for (int r = 0; r < NR; r++) begin refLo[r] = 0; refHi[r] = 0; end
      refPend = 0;
    end else begin
      for (int r = 0; r < NR; r++) rel[r] = refPend && inAcc(r);
      for (int p = 0; p < NW; p++) if (wrValid[p]) rel[int'(wrAddr[p*AW +: AW])] = 1;
      for (int h = 0; h < NH; h++) if (hintValid[h]) rel[int'(hintAddr[h*AW +: AW])] = 1;
      for (int r = 0; r < NR; r++) begin
        if (rel[r]) begin refLo[r] = 0; refHi[r] = 0; end
        if (setValid && setBits[r])      refLo[r] = 1;
        if (setValid && setBits[NR + r]) refHi[r] = 1;
      end
      refPend = wclrFire;
    end
    #1;
    check(req, sbState, refVec());
  endtask

  task automatic fillAll(string req);
    idle(); setValid = 1'b1; setBits = '1;
    tick(req);
    idle();
  endtask

  initial begin
    idle();
    wrAddr = '0; hintAddr = '0;
    tick("R1");
    tick("R1");
    check("R1", sbState, '0);
    rstN = 1'b1;
    tick("R1");
    check("R1", sbState, '0);

    // R4: full set, then a half-specific single bit after a clear.
    fillAll("R4");
    check("R4", sbState, '1);

    // R2: all six write ports release distinct registers.
    wrValid = '1;
    wrAddr = {6'd63, 6'd48, 6'd33, 6'd17, 6'd5, 6'd0};
    tick("R2");
    check("R2", SW'({sbState[NR+5], sbState[5], sbState[NR+63], sbState[63]}), '0);
    idle();

    // R9: addresses present but valids low.
    wrAddr = {6'd1, 6'd2, 6'd3, 6'd4, 6'd6, 6'd7};
    hintAddr = {6'd8, 6'd9, 6'd10, 6'd11};
    tick("R9");
    check("R9", SW'({sbState[NR+1], sbState[1], sbState[8]}), SW'(3'b111));

    // R3: hints release with no data.
    hintValid = '1;
    tick("R3");
    check("R3", SW'({sbState[NR+8], sbState[11]}), '0);
    idle();

    // R10: two write ports share address 20, plus a hint and a third write.
    wrValid = 6'b000111;
    wrAddr = {6'd0, 6'd0, 6'd0, 6'd21, 6'd20, 6'd20};
    hintValid = 4'b0001; hintAddr = {6'd0, 6'd0, 6'd0, 6'd22};
    tick("R10");
    check("R10", SW'({sbState[NR+20], sbState[21], sbState[NR+22]}), '0);
    idle();

    // R4 mapping: only setBits bit NR+3 lands in the high half.
    setValid = 1'b1; setBits = '0; setBits[NR+3] = 1'b1;
    tick("R4");
    idle();

    // R5: set everything while releasing 30 and 31.
    setValid = 1'b1; setBits = '1;
    wrValid = 6'b000001; wrAddr = {30'd0, 6'd30};
    hintValid = 4'b0001; hintAddr = {18'd0, 6'd31};
    tick("R5");
    check("R5", sbState, '1);
    idle();

    // R6/R7: deferred accumulator release.
    wclrFire = 1'b1;
    tick("R6");
    check("R6", SW'({sbState[NR+55], sbState[48]}), SW'(2'b11));
    idle();
    tick("R6");
    check("R6", SW'({sbState[NR+48], sbState[55], sbState[48]}), '0);
    check("R7", SW'({sbState[NR+56], sbState[NR+47], sbState[56], sbState[47]}), SW'(4'hF));
    tick("R7");

    // R8: set lands on the edge of the deferred clear.
    fillAll("R8");
    wclrFire = 1'b1;
    tick("R8");
    idle();
    setValid = 1'b1; setBits[50] = 1'b1; setBits[NR+52] = 1'b1;
    tick("R8");
    check("R8", SW'({sbState[NR+52], sbState[50], sbState[51], sbState[NR+50]}), SW'(4'b1100));
    idle();

    // Random traffic against the reference.
    for (int i = 0; i < 3000; i++) begin
      wrValid = NW'($urandom);
      wrAddr = {$urandom, $urandom};
      hintValid = NH'($urandom);
      hintAddr = NH*AW'($urandom);
      setValid = ($urandom % 4) == 0;
      setBits = {$urandom & $urandom, $urandom & $urandom, $urandom & $urandom, $urandom & $urandom};
      wclrFire = ($urandom % 16) == 0;
      tick("random R2 R3 R4 R5 R6 R8");
    end
    idle();
    tick("random");

    // R1: reset mid-run.
    fillAll("R1");
    rstN = 1'b0;
    tick("R1");
    check("R1", sbState, '0);
    rstN = 1'b1;
    tick("R1");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule